// File: doc/BRIEF.md
# UART Transmit Holding Register Control

This block is the transmit front end of one serial channel. A CPU writes a character into an 8-bit holding register. An empty flag tells software when that register can take the next character. When the transmitter is enabled and the serializer signals that its shift register can take a character, the block passes the held character across, trimmed to the selected character length, and sets the empty flag again in the same clock edge.

Software can abort at any time by writing 0 to the transmitter enable. This discards any pending character and forces the register back to empty. A completion flag reports that the serializer has finished its last bit with nothing left to send. This flag is raised only for a character that was actually handed to the serializer, so an abort before the hand-off never produces it. The flag is cleared by a write-one strobe. A level interrupt follows the empty flag, gated by an enable input.

Top module: `uart_txh_top`

## Requirements
- R1: After reset the holding register reads 0x00, the empty flag is 1, the completion flag and the transmitter enable are 0, and no hand-off is signalled.
- R2: A bus write made while the empty flag is 1 stores the written byte and clears the empty flag. Both take effect on the next clock edge.
- R3: A bus write made while the empty flag is 0 is ignored, and the stored byte stays unchanged.
- R4: When the enable is 1, the empty flag is 0 and the serializer ready input is high, the load output is high for exactly one cycle after that edge, and the empty flag is 1 from that same edge.
- R5: No hand-off happens while the enable is 0 or the empty flag is 1.
- R6: The handed-off character keeps its low bits and has all higher bits at 0. The length select code sets how many low bits are kept: 00 keeps 5, 01 keeps 6, 10 keeps 7 and 11 keeps 8.
- R7: The interrupt output is high exactly when the empty flag and the interrupt enable input are both 1.
- R8: A write of 0 to the enable forces the empty flag to 1 on the next edge. It also blocks any hand-off in that cycle. If a bus write comes in the same cycle, its byte is stored, but the flag still ends at 1.
- R9: The completion flag is set when the serializer reports its last bit while a handed-off character is in flight and the empty flag is 1.
- R10: A write of 0 to the enable ends the in-flight state. A later last-bit report then does not set the completion flag, so an abort before the hand-off never produces completion.
- R11: The clear strobe resets the completion flag. If a set condition happens in the same cycle, the set wins.
- R12: The enable output takes the value of each enable write on the next edge and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe for the holding register |
| wr_data | input | 8 | Bus write data |
| en_wr | input | 1 | Write strobe for the transmitter enable |
| en_wdata | input | 1 | Value written to the enable |
| len_sel | input | 2 | Character length code |
| irq_en | input | 1 | Empty interrupt enable |
| shf_ready | input | 1 | Serializer can take a character |
| last_bit | input | 1 | Serializer finished its final bit |
| cpl_clr | input | 1 | Write-one clear of the completion flag |
| hold_data | output | 8 | Holding register contents |
| tx_en | output | 1 | Current transmitter enable |
| empty | output | 1 | Holding register empty flag |
| shf_load | output | 1 | One-cycle hand-off pulse |
| shf_data | output | 8 | Character passed to the shift register |
| cpl_flag | output | 1 | Transfer complete flag |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The hardest case to reach is an abort that races with the serializer. Examples are a write of 0 to the enable in the same cycle as a ready request, a last-bit report or a bus write, or a character that is aborted before its hand-off and then followed by a stale last-bit report. Directed steps walk the write, abort and last-bit order explicitly. The random phase then drives rare enable writes and last-bit pulses alongside frequent ready requests, so that these collisions happen many times. A reference model in the bench predicts every output.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
    localparam int DATA_W  = 8;
    localparam int LEN_W   = 2;
    localparam int MIN_LEN = 5;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              load;
        logic [DATA_W-1:0] sdata;
    } hold_st_t;

    typedef struct packed {
        logic fly;
        logic cpl;
    } cpl_st_t;

    typedef struct packed {
        logic en;
    } ctl_st_t;
endpackage

// File: rtl/uart_txh_mask.sv
module uart_txh_mask
    import uart_txh_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len_sel,
    output logic [DATA_W-1:0] dout
);
    localparam int KEEP_BASE = MIN_LEN;
    logic [DATA_W-1:0] keep;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign keep[i] = ((i + 1) <= (KEEP_BASE + int'(len_sel)));
    end

    assign dout = din & keep;
endmodule

// File: rtl/uart_txh_ctl.sv
module uart_txh_ctl
    import uart_txh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_wdata,
    output logic tx_en,
    output logic abort
);
    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) st_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_en = st_q.en;
    assign abort = en_wr && !en_wdata;
endmodule

// File: rtl/uart_txh_hold.sv
module uart_txh_hold
    import uart_txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              abort,
    input  logic              shf_ready,
    input  logic [LEN_W-1:0]  len_sel,
    output logic              hand,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty,
    output logic              shf_load,
    output logic [DATA_W-1:0] shf_data
);
    hold_st_t          st_d, st_q;
    logic [DATA_W-1:0] trimmed;

    uart_txh_mask u_mask (
        .din     (st_q.hold),
        .len_sel (len_sel),
        .dout    (trimmed)
    );

    assign hand = tx_en && !st_q.empty && shf_ready && !abort;

    always_comb begin
        st_d      = st_q;
        st_d.load = hand;
        if (wr_en && st_q.empty) begin
            st_d.hold  = wr_data;
            st_d.empty = 1'b0;
        end
        if (hand) begin
            st_d.empty = 1'b1;
            st_d.sdata = trimmed;
        end
        if (abort) st_d.empty = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_data = st_q.hold;
    assign empty     = st_q.empty;
    assign shf_load  = st_q.load;
    assign shf_data  = st_q.sdata;
endmodule

// File: rtl/uart_txh_cpl.sv
module uart_txh_cpl
    import uart_txh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hand,
    input  logic abort,
    input  logic last_bit,
    input  logic empty,
    input  logic cpl_clr,
    output logic cpl_flag
);
    cpl_st_t st_d, st_q;
    logic    set_cpl;

    assign set_cpl = last_bit && st_q.fly && empty && !abort;

    always_comb begin
        st_d = st_q;
        if (abort)         st_d.fly = 1'b0;
        else if (hand)     st_d.fly = 1'b1;
        else if (last_bit) st_d.fly = 1'b0;
        if (set_cpl)       st_d.cpl = 1'b1;
        else if (cpl_clr)  st_d.cpl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpl_flag = st_q.cpl;
endmodule

// File: rtl/uart_txh_top.sv
module uart_txh_top
    import uart_txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              irq_en,
    input  logic              shf_ready,
    input  logic              last_bit,
    input  logic              cpl_clr,
    output logic [DATA_W-1:0] hold_data,
    output logic              tx_en,
    output logic              empty,
    output logic              shf_load,
    output logic [DATA_W-1:0] shf_data,
    output logic              cpl_flag,
    output logic              irq
);
    logic abort;
    logic hand;

    uart_txh_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .tx_en    (tx_en),
        .abort    (abort)
    );

    uart_txh_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_en     (tx_en),
        .abort     (abort),
        .shf_ready (shf_ready),
        .len_sel   (len_sel),
        .hand      (hand),
        .hold_data (hold_data),
        .empty     (empty),
        .shf_load  (shf_load),
        .shf_data  (shf_data)
    );

    uart_txh_cpl u_cpl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hand     (hand),
        .abort    (abort),
        .last_bit (last_bit),
        .empty    (empty),
        .cpl_clr  (cpl_clr),
        .cpl_flag (cpl_flag)
    );

    assign irq = empty && irq_en;
endmodule

// File: rtl/uart_txh_chk.sv
module uart_txh_chk
    import uart_txh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              en_wr,
    input logic              en_wdata,
    input logic              last_bit,
    input logic              cpl_clr,
    input logic [DATA_W-1:0] hold_data,
    input logic              tx_en,
    input logic              empty,
    input logic              shf_load,
    input logic              cpl_flag
);
    AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && empty) |=> (hold_data == $past(wr_data)));                 // R2
    AST_WR_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !empty) |=> $stable(hold_data));                           // R3
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        shf_load |-> empty);                                                 // R4
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shf_load |=> !shf_load);                                             // R4
    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en || empty) |=> !shf_load);                                    // R5
    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata) |=> empty);                                     // R8
    AST_ABORT_NO_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_wdata && !cpl_flag) |=> !cpl_flag);                    // R10
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_clr && !last_bit) |=> !cpl_flag);                               // R11
    AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (tx_en == $past(en_wdata)));                               // R12
endmodule

bind uart_txh_top uart_txh_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .last_bit  (last_bit),
    .cpl_clr   (cpl_clr),
    .hold_data (hold_data),
    .tx_en     (tx_en),
    .empty     (empty),
    .shf_load  (shf_load),
    .cpl_flag  (cpl_flag)
);

// File: tb/uart_txh_top_tb.sv
module uart_txh_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic [1:0] len_sel = '0;
    logic       irq_en = 1'b0;
    logic       shf_ready = 1'b0;
    logic       last_bit = 1'b0;
    logic       cpl_clr = 1'b0;
    logic [7:0] hold_data, shf_data;
    logic       tx_en, empty, shf_load, cpl_flag, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_hold = '0, m_sdata = '0;
    logic       m_empty = 1'b1, m_en = 1'b0, m_load = 1'b0, m_fly = 1'b0, m_cpl = 1'b0;

    always #5 clk = ~clk;

    uart_txh_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_wr(en_wr), .en_wdata(en_wdata), .len_sel(len_sel), .irq_en(irq_en),
        .shf_ready(shf_ready), .last_bit(last_bit), .cpl_clr(cpl_clr),
        .hold_data(hold_data), .tx_en(tx_en), .empty(empty), .shf_load(shf_load),
        .shf_data(shf_data), .cpl_flag(cpl_flag), .irq(irq)
    );

    function automatic logic [7:0] trim(input logic [7:0] d, input logic [1:0] l);
        case (l)
            2'd0:    return d & 8'h1F;
            2'd1:    return d & 8'h3F;
            2'd2:    return d & 8'h7F;
            default: return d;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(hold_data == m_hold, "R2/R3 hold", hold_data, m_hold);
        chk(empty == m_empty, "R4/R8 empty", empty, m_empty);
        chk(shf_load == m_load, "R4/R5 load", shf_load, m_load);
        chk(shf_data == m_sdata, "R6 sdata", shf_data, m_sdata);
        chk(irq == (m_empty && irq_en), "R7 irq", irq, m_empty && irq_en);
        chk(cpl_flag == m_cpl, "R9/R10/R11 cpl", cpl_flag, m_cpl);
        chk(tx_en == m_en, "R12 tx_en", tx_en, m_en);
    endtask

    task automatic drive(input bit w, input logic [7:0] wd, input bit ew, input bit ev,
                         input logic [1:0] l, input bit ie, input bit rdy, input bit lb, input bit clr);
        bit ab, hd, acc, setc;
        wr_en = w; wr_data = wd; en_wr = ew; en_wdata = ev; len_sel = l;
        irq_en = ie; shf_ready = rdy; last_bit = lb; cpl_clr = clr;
        ab   = ew && !ev;
        hd   = m_en && !m_empty && rdy && !ab;
        acc  = w && m_empty;
        setc = lb && m_fly && m_empty && !ab;
        if (hd) m_sdata = trim(m_hold, l);
        m_load = hd;
        if (acc) begin m_hold = wd; m_empty = 1'b0; end
        if (hd || ab) m_empty = 1'b1;
        if (ew) m_en = ev;
        if (ab) m_fly = 1'b0; else if (hd) m_fly = 1'b1; else if (lb) m_fly = 1'b0;
        if (setc) m_cpl = 1'b1; else if (clr) m_cpl = 1'b0;
    endtask

    task automatic step(input bit w, input logic [7:0] wd, input bit ew, input bit ev,
                        input logic [1:0] l, input bit ie, input bit rdy, input bit lb, input bit clr);
        drive(w, wd, ew, ev, l, ie, rdy, lb, clr);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1703));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(hold_data == 8'h00 && empty && !cpl_flag && !tx_en && !shf_load, "R1 reset", hold_data, 0);
        check_all();
        step(1, 8'hFF, 0, 0, 2'd0, 0, 0, 0, 0);
        chk(hold_data == 8'hFF && !empty, "R2 accept", hold_data, 8'hFF);
        step(1, 8'h12, 0, 0, 2'd0, 0, 0, 0, 0);
        chk(hold_data == 8'hFF, "R3 ignored", hold_data, 8'hFF);
        step(0, 8'h00, 1, 1, 2'd0, 0, 0, 0, 0);
        chk(tx_en, "R12 enable", tx_en, 1);
        step(0, 8'h00, 0, 0, 2'd0, 0, 1, 0, 0);
        chk(shf_load && empty, "R4 handoff", shf_load, 1);
        chk(shf_data == 8'h1F, "R6 len5", shf_data, 8'h1F);
        step(0, 8'h00, 0, 0, 2'd0, 0, 0, 0, 0);
        chk(!shf_load, "R4 single pulse", shf_load, 0);
        step(0, 8'h00, 0, 0, 2'd0, 0, 0, 1, 0);
        chk(cpl_flag, "R9 complete", cpl_flag, 1);
        step(0, 8'h00, 0, 0, 2'd0, 0, 0, 0, 1);
        chk(!cpl_flag, "R11 clear", cpl_flag, 0);
        step(1, 8'hA5, 0, 0, 2'd2, 1, 0, 0, 0);
        chk(!irq, "R7 irq low when full", irq, 0);
        step(0, 8'h00, 1, 0, 2'd2, 1, 1, 0, 0);
        chk(empty && irq && !tx_en, "R8 abort empties", empty, 1);
        step(0, 8'h00, 0, 0, 2'd2, 1, 1, 0, 0);
        chk(!shf_load, "R5 disabled no handoff", shf_load, 0);
        step(0, 8'h00, 0, 0, 2'd2, 1, 0, 1, 0);
        chk(!cpl_flag, "R10 abort no complete", cpl_flag, 0);
        step(0, 8'h00, 1, 1, 2'd2, 1, 0, 0, 0);
        step(1, 8'hF7, 0, 0, 2'd2, 1, 1, 0, 0);
        step(0, 8'h00, 0, 0, 2'd2, 1, 1, 0, 0);
        chk(shf_data == 8'h77, "R6 len7", shf_data, 8'h77);
        step(0, 8'h00, 0, 0, 2'd1, 1, 0, 1, 1);
        chk(cpl_flag, "R11 set wins", cpl_flag, 1);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) == 0, 8'($urandom),
                 ($urandom % 12) == 0, ($urandom % 4) != 0,
                 2'($urandom), 1'($urandom), ($urandom % 3) != 0,
                 ($urandom % 6) == 0, ($urandom % 9) == 0);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule